// File: doc/BRIEF.md
# Masked Memory-Type Range Classifier

This block sorts every physical address it is given into one of three memory types: cacheable, uncacheable or write-combinable. The sorting is set by a single 64-bit control word. That word describes two address windows. Each window has a base, a mask and two attribute flags. A window covers the addresses whose upper bits agree with its base in every bit position where its mask holds a one. Windows are placed on 128-Kbyte boundaries, so only the top 15 bits of a 32-bit address are compared.

Software loads the control word through a plain write port and can read it back whole. The address side has no clock stage by default: the type is available in the same cycle as the address. A build parameter inserts one register stage on the three type outputs. When no active window claims an address, it is cacheable. If both attribute kinds apply to an address, the uncacheable attribute wins.

Top module: `mem_range_classifier`

## Requirements
- R1: While reset is held and after it is released, the control word reads as zero and the address decision is cacheable for every address.
- R2: A write with `cfg_we` high is captured at the rising clock edge. From that edge on, `cfg_rdata` returns exactly the written 64 bits. Without a write, `cfg_rdata` does not change.
- R3: Window n occupies control bits [32n+31:32n]. Inside that half, bits 31:17 hold the base, bits 16:2 hold the mask, bit 1 is the write-combine flag and bit 0 is the uncacheable flag.
- R4: An address lies in window n exactly when (base & mask) equals (addr[31:17] & mask). addr[16:0] never affects the result.
- R5: A window with an all-zero mask covers every address. A window with an all-ones mask covers only the one 128-Kbyte block whose top 15 bits equal its base.
- R6: An address covered by a window whose write-combine flag is 1 is reported as write-combinable (`is_write_combine` = 1), provided no covering window has its uncacheable flag set.
- R7: An address covered by a window whose uncacheable flag is 1 is reported as uncacheable (`is_uncacheable` = 1).
- R8: A window whose two flags are both 0 has no effect, even where it covers the address. An address with no covering flagged window is cacheable (`is_cacheable` = 1).
- R9: Where the uncacheable and write-combine attributes both apply, whether from one window or from two overlapping ones, the result is uncacheable and `is_write_combine` stays 0.
- R10: In every cycle exactly one of `is_cacheable`, `is_uncacheable` and `is_write_combine` is 1.
- R11: With REG_OUT = 1, the three outputs reset to cacheable. They then show, one cycle later, the decision for the address and control word that were present at the previous rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Write strobe for the control word |
| cfg_wdata | input | 64 | Value to be written to the control word |
| cfg_rdata | output | 64 | Current control word |
| addr | input | 32 | Physical address to classify |
| is_cacheable | output | 1 | Address is ordinary cacheable memory |
| is_uncacheable | output | 1 | Address is uncacheable |
| is_write_combine | output | 1 | Address is write-combinable |

## Verification
A write becomes visible on `cfg_rdata` and in the default unregistered decision right after the rising edge that captures it. The bench therefore drives its inputs on the falling edge and compares after the next rising edge, against a model that has already applied the write. In the registered build, the outputs at that same sample point reflect the control word from before the write together with the current address. A second instance is checked against the model's previous control value, so both latencies are checked in every cycle.

// File: rtl/mtc_pkg.sv
package mtc_pkg;

    // Resolved memory type of one address
    typedef enum logic [1:0] {
        MK_CACHE   = 2'd0,
        MK_UNCACHE = 2'd1,
        MK_WCOMB   = 2'd2
    } mem_kind_e;

    // One-hot view presented at the block's edge
    typedef struct packed {
        logic cache;
        logic uncache;
        logic wcomb;
    } kind_onehot_t;

    function automatic kind_onehot_t kind_to_onehot(mem_kind_e k);
        kind_onehot_t o;
        o.cache   = (k == MK_CACHE);
        o.uncache = (k == MK_UNCACHE);
        o.wcomb   = (k == MK_WCOMB);
        return o;
    endfunction

endpackage

// File: rtl/mtc_cfg_reg.sv
module mtc_cfg_reg #(
    parameter int CFG_W = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [CFG_W-1:0] wdata,
    output logic [CFG_W-1:0] value
);

    typedef struct packed {
        logic [CFG_W-1:0] word;
    } cfg_state_t;

    cfg_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (we) begin
            state_d.word = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign value = state_q.word;

endmodule

// File: rtl/mtc_range_match.sv
module mtc_range_match #(
    parameter int FIELD_W = 15,
    localparam int ENTRY_W = 2 * FIELD_W + 2
) (
    input  logic [ENTRY_W-1:0] entry,
    input  logic [FIELD_W-1:0] page,
    output logic               hit_uc,
    output logic               hit_wc
);

    logic [FIELD_W-1:0] base_f;
    logic [FIELD_W-1:0] mask_f;
    logic               flag_wc;
    logic               flag_uc;
    logic               covered;

    // Field layout of one window: base | mask | wc | uc
    assign base_f  = entry[ENTRY_W-1 -: FIELD_W];
    assign mask_f  = entry[FIELD_W+1 : 2];
    assign flag_wc = entry[1];
    assign flag_uc = entry[0];

    // Bits where the mask is 1 must agree between base and page
    assign covered = (((base_f ^ page) & mask_f) == '0);

    assign hit_uc = covered & flag_uc;
    assign hit_wc = covered & flag_wc;

endmodule

// File: rtl/mtc_resolve.sv
module mtc_resolve
    import mtc_pkg::*;
#(
    parameter int NUM_RANGES = 2,
    parameter bit REG_OUT    = 1'b0
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_RANGES-1:0] uc_vec,
    input  logic [NUM_RANGES-1:0] wc_vec,
    output kind_onehot_t          kind
);

    mem_kind_e    kind_now;
    kind_onehot_t onehot_now;

    // Uncacheable outranks write-combine, which outranks the default
    always_comb begin
        if (|uc_vec) begin
            kind_now = MK_UNCACHE;
        end else if (|wc_vec) begin
            kind_now = MK_WCOMB;
        end else begin
            kind_now = MK_CACHE;
        end
        onehot_now = kind_to_onehot(kind_now);
    end

    generate
        if (REG_OUT) begin : g_reg
            typedef struct packed {
                kind_onehot_t kind;
            } out_state_t;

            out_state_t out_d, out_q;

            always_comb begin
                out_d      = out_q;
                out_d.kind = onehot_now;
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    out_q <= '{kind: kind_to_onehot(MK_CACHE)};
                end else begin
                    out_q <= out_d;
                end
            end

            assign kind = out_q.kind;
        end else begin : g_comb
            logic unused_clk;
            assign unused_clk = clk ^ rst_n;
            assign kind = onehot_now;
        end
    endgenerate

endmodule

// File: rtl/mem_range_classifier.sv
module mem_range_classifier
    import mtc_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int GRAN_BITS  = 17,
    parameter int NUM_RANGES = 2,
    parameter bit REG_OUT    = 1'b0,
    localparam int FIELD_W   = ADDR_W - GRAN_BITS,
    localparam int ENTRY_W   = 2 * FIELD_W + 2,
    localparam int CFG_W     = NUM_RANGES * ENTRY_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [CFG_W-1:0]  cfg_wdata,
    output logic [CFG_W-1:0]  cfg_rdata,
    input  logic [ADDR_W-1:0] addr,
    output logic              is_cacheable,
    output logic              is_uncacheable,
    output logic              is_write_combine
);

    logic [CFG_W-1:0]      cfg_word;
    logic [NUM_RANGES-1:0] uc_vec;
    logic [NUM_RANGES-1:0] wc_vec;
    logic [FIELD_W-1:0]    page;
    kind_onehot_t          kind;

    assign page = addr[ADDR_W-1:GRAN_BITS];

    mtc_cfg_reg #(
        .CFG_W (CFG_W)
    ) u_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .wdata (cfg_wdata),
        .value (cfg_word)
    );

    generate
        for (genvar n = 0; n < NUM_RANGES; n++) begin : g_range
            mtc_range_match #(
                .FIELD_W (FIELD_W)
            ) u_match (
                .entry  (cfg_word[n*ENTRY_W +: ENTRY_W]),
                .page   (page),
                .hit_uc (uc_vec[n]),
                .hit_wc (wc_vec[n])
            );
        end
    endgenerate

    mtc_resolve #(
        .NUM_RANGES (NUM_RANGES),
        .REG_OUT    (REG_OUT)
    ) u_resolve (
        .clk    (clk),
        .rst_n  (rst_n),
        .uc_vec (uc_vec),
        .wc_vec (wc_vec),
        .kind   (kind)
    );

    assign cfg_rdata        = cfg_word;
    assign is_cacheable     = kind.cache;
    assign is_uncacheable   = kind.uncache;
    assign is_write_combine = kind.wcomb;

endmodule

// File: rtl/mem_range_classifier_chk.sv
module mem_range_classifier_chk #(
    parameter int CFG_W   = 64,
    parameter int ENTRY_W = 32,
    parameter int FIELD_W = 15,
    parameter bit REG_OUT = 1'b0
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_we,
    input logic [CFG_W-1:0] cfg_wdata,
    input logic [CFG_W-1:0] cfg_rdata,
    input logic             is_cacheable,
    input logic             is_uncacheable,
    input logic             is_write_combine
);

    logic no_flags;
    logic uc0_all;

    // No window carries any attribute flag
    always_comb begin
        no_flags = 1'b1;
        for (int n = 0; n < CFG_W / ENTRY_W; n++) begin
            if (cfg_rdata[n*ENTRY_W] || cfg_rdata[n*ENTRY_W+1]) begin
                no_flags = 1'b0;
            end
        end
    end

    // Window 0 covers everything and is uncacheable
    assign uc0_all = cfg_rdata[0] && (cfg_rdata[FIELD_W+1:2] == '0);

    // R10
    one_type_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({is_cacheable, is_uncacheable, is_write_combine}) == 1);

    // R2
    write_visible_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> (cfg_rdata == $past(cfg_wdata)));

    // R2
    hold_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_we |=> $stable(cfg_rdata));

    generate
        if (REG_OUT) begin : g_reg
            // R8
            flagless_cache_chk: assert property (@(posedge clk) disable iff (!rst_n)
                no_flags |=> is_cacheable);

            // R7
            uc_everywhere_chk: assert property (@(posedge clk) disable iff (!rst_n)
                uc0_all |=> is_uncacheable);
        end else begin : g_comb
            // R8
            flagless_cache_chk: assert property (@(posedge clk) disable iff (!rst_n)
                no_flags |-> is_cacheable);

            // R7
            uc_everywhere_chk: assert property (@(posedge clk) disable iff (!rst_n)
                uc0_all |-> is_uncacheable);
        end
    endgenerate

endmodule

bind mem_range_classifier mem_range_classifier_chk #(
    .CFG_W   (CFG_W),
    .ENTRY_W (ENTRY_W),
    .FIELD_W (FIELD_W),
    .REG_OUT (REG_OUT)
) u_chk (
    .clk              (clk),
    .rst_n            (rst_n),
    .cfg_we           (cfg_we),
    .cfg_wdata        (cfg_wdata),
    .cfg_rdata        (cfg_rdata),
    .is_cacheable     (is_cacheable),
    .is_uncacheable   (is_uncacheable),
    .is_write_combine (is_write_combine)
);

// File: tb/test_mem_range_classifier.sv
`timescale 1ns/1ps
module test_mem_range_classifier;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [63:0] cfg_wdata = '0;
    logic [31:0] addr = '0;
    logic [63:0] rd_c, rd_r;
    logic        c_c, u_c, w_c;
    logic        c_r, u_r, w_r;

    int checks = 0;
    int errors = 0;
    logic [63:0] ref_cfg = '0;
    logic [63:0] ref_prev = '0;

    always #4 clk = ~clk;

    mem_range_classifier i_mem_range_classifier (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .cfg_rdata(rd_c), .addr(addr),
        .is_cacheable(c_c), .is_uncacheable(u_c), .is_write_combine(w_c));

    mem_range_classifier #(.REG_OUT(1'b1)) i_mem_range_classifier_reg (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .cfg_rdata(rd_r), .addr(addr),
        .is_cacheable(c_r), .is_uncacheable(u_r), .is_write_combine(w_r));

    // Window half: base[31:17] mask[16:2] wc[1] uc[0]  (R3)
    function automatic logic [31:0] win(logic [14:0] b, logic [14:0] m, bit wc, bit uc);
        return {b, m, wc, uc};
    endfunction

    // Expected {cacheable, uncacheable, write_combine}
    function automatic logic [2:0] model(logic [63:0] r, logic [31:0] a);
        bit any_uc = 0;
        bit any_wc = 0;
        for (int n = 0; n < 2; n++) begin
            logic [31:0] half = r[32*n +: 32];
            int b = int'(half[31:17]);
            int m = int'(half[16:2]);
            int p = int'(a[31:17]);
            if ((b & m) == (p & m)) begin
                if (half[0]) any_uc = 1;
                if (half[1]) any_wc = 1;
            end
        end
        if (any_uc) return 3'b010;
        if (any_wc) return 3'b001;
        return 3'b100;
    endfunction

    task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Drive one cycle at the falling edge, compare at the next falling edge
    task automatic cyc(string tag, bit we, logic [63:0] wd, logic [31:0] a);
        cfg_we    = we;
        cfg_wdata = wd;
        addr      = a;
        ref_prev  = ref_cfg;
        if (we) ref_cfg = wd;
        @(negedge clk);
        check("R2 readback", rd_c, ref_cfg);
        check({tag, " comb"}, {61'd0, c_c, u_c, w_c}, {61'd0, model(ref_cfg, a)});
        check("R10 one-hot", 64'($countones({c_c, u_c, w_c})), 64'd1);
        check("R11 registered", {61'd0, c_r, u_r, w_r}, {61'd0, model(ref_prev, a)});
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 rdata in reset", rd_c, 64'd0);
        check("R1 comb type in reset", {61'd0, c_c, u_c, w_c}, 64'b100);
        check("R11 reg type in reset", {61'd0, c_r, u_r, w_r}, 64'b100);
        rst_n = 1'b1;
        cyc("R1", 0, '0, 32'hFFFF_FFFF);
        cyc("R1", 0, '0, 32'h0000_0000);

        // R5 / R7: zero mask in window 0 covers all
        cyc("R7", 1, {32'd0, win(15'h1234, 15'h0000, 0, 1)}, 32'h8000_0000);
        cyc("R5", 0, '0, 32'h0001_2345);
        cyc("R2 hold", 0, '0, 32'hDEAD_BEEF);

        // R5: all-ones mask covers one block only
        cyc("R5", 1, {32'd0, win(15'h0123, 15'h7FFF, 0, 1)}, {15'h0123, 17'h1FFFF});
        cyc("R5", 0, '0, {15'h0123, 17'h00000});
        cyc("R5", 0, '0, {15'h0124, 17'h00000});
        cyc("R5", 0, '0, {15'h0122, 17'h1FFFF});

        // R4: partial mask, low bits ignored
        cyc("R4", 1, {32'd0, win(15'h7F00, 15'h7F00, 0, 1)}, 32'hFE00_0000);
        cyc("R4", 0, '0, 32'hFFFF_FFFF);
        cyc("R4", 0, '0, 32'hFC1F_FFFF);

        // R3/R6: window 1 in the upper half, write-combine only
        cyc("R6", 1, {win(15'h0040, 15'h7FF0, 1, 0), 32'd0}, {15'h0045, 17'h0ABCD});
        cyc("R3", 0, '0, {15'h0050, 17'h0});
        // R8: both flags 0, full cover
        cyc("R8", 1, {win(15'h0, 15'h0, 0, 0), win(15'h0, 15'h0, 0, 0)}, 32'h1234_5678);
        cyc("R8", 1, {win(15'h0, 15'h0, 0, 0), win(15'h10, 15'h7FFF, 1, 0)}, {15'h10, 17'h0});
        // R9: both flags in one window, and across windows
        cyc("R9", 1, {32'd0, win(15'h0, 15'h0, 1, 1)}, 32'h4000_0000);
        cyc("R9", 1, {win(15'h0, 15'h0, 0, 1), win(15'h0, 15'h0, 1, 0)}, 32'h0F00_0000);
        cyc("R9", 1, {win(15'h0, 15'h0, 1, 0), win(15'h0, 15'h0, 0, 1)}, 32'h0F00_0000);
        cyc("R2", 1, 64'hA5A5_5A5A_0F0F_F0F0, 32'h0);

        // Random sweep
        for (int i = 0; i < 2000; i++) begin
            bit we = ($urandom_range(0, 3) == 0);
            logic [63:0] wd = {$urandom, $urandom};
            logic [31:0] a = $urandom;
            if ($urandom_range(0, 3) == 0) wd[16:2] = '0;
            if ($urandom_range(0, 3) == 0) wd[48:34] = 15'h7FFF;
            if ($urandom_range(0, 1) == 0)
                a[31:17] = ref_cfg[$urandom_range(0, 1) ? 63 : 31 -: 15];
            cyc("R4 random", we, wd, a);
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule